// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block collects interrupt events for the management register file of a phoneline network transceiver. It holds two 16-bit registers. The interrupt status register records pending events: six hardware sources set their bits, and six further bits are set and cleared directly by software. The interrupt mask register chooses which of the pending bits may pull the active-low interrupt pin.

Software reaches both registers through a simple word port with an address, write data, a write strobe and a read strobe. Most hardware-sourced status bits are cleared by writing 1 to them. The bit that flags a valid received command word is different. It is cleared as a side effect when the host accesses the high byte of that command word, which lives in another register. A separate strobe input reports that access. When a hardware event and a clear arrive in the same cycle, the event wins.

The interrupt pin is registered. It reflects the mask and status contents one clock after they change.

Top module: `phl_irq_ctrl`

## Requirements
- R1: After synchronous active-low reset, both registers read 0 and `irq_n` is 1.
- R2: The mask register is at address 18. Bits 15..8 and 3..0 are read/write. Bits 7..4 always read 0 and ignore writes.
- R3: Status bits 15..10, at address 19, are software interrupts. A write loads them with the written value, so a write can both set and clear them.
- R4: A one-cycle event pulse sets a status bit, and the bit then holds. The events and their bits are: `ev_txcmd_rdy` sets bit 8, `ev_pkt_rx` sets bit 3, `ev_pkt_tx` sets bit 2, `ev_rcmd_rx` sets bit 1 and `ev_rcmd_tx` sets bit 0.
- R5: Writing 1 to status bit 8 or to bits 3..0 clears that bit. Writing 0 to any of them leaves it unchanged.
- R6: `ev_rxcmd_vld` sets status bit 9, and `rxcmd_hi_acc` clears it. Register writes to bit 9 have no effect.
- R7: If a hardware event and a clear of the same bit (write-1 or high-byte access) occur in one cycle, the bit ends up set.
- R8: A status read returns every pending bit, whatever the mask holds. The mask itself does not change the status register.
- R9: `irq_n` is 0 exactly when (status AND NOT mask) was non-zero in the previous cycle. It changes one cycle after the registers change.
- R10: `reg_rdata` is 0 when `reg_rd` is low or the address matches neither register. Status bits 7..4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 16 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 16 | Read data (combinational) |
| rxcmd_hi_acc | input | 1 | Access to the received command word's high byte |
| ev_rxcmd_vld | input | 1 | Non-null received command word arrived |
| ev_txcmd_rdy | input | 1 | Transmit command word ready |
| ev_pkt_rx | input | 1 | Packet received |
| ev_pkt_tx | input | 1 | Packet transmitted |
| ev_rcmd_rx | input | 1 | Remote command received |
| ev_rcmd_tx | input | 1 | Remote command sent |
| irq_n | output | 1 | Active-low interrupt pin |

## Verification
Directed sequences check each class of status bit on its own: software bits loaded by writes, write-1-to-clear bits hit with 0 and with 1, and the side-cleared bit hit with writes and with high-byte accesses. Each of these is also tried with a coinciding event, which separates set-wins from clear-wins. Masking tests set a pending bit under a full mask and under a single open mask bit, which separates a status path that depends on the mask from a pin path that ignores it. The pin is sampled in the first and second cycle after a change, which exposes a missing or an extra register stage. A long random phase mixes all strobes and addresses, including reserved bits and unmapped addresses, against a bench model.

// File: rtl/phl_irq_pkg.sv
// Package: bit layout and per-bit behaviour class of the interrupt registers.
// Assumes a fixed 16-bit register word.
package phl_irq_pkg;
    localparam int DATA_W = 16;

    // Behaviour class of one status bit.
    typedef enum logic [1:0] {
        K_NONE = 2'd0,  // reserved, constant 0
        K_SW   = 2'd1,  // software loaded
        K_W1C  = 2'd2,  // hardware set, write-1-to-clear
        K_SIDE = 2'd3   // hardware set, cleared by a side access
    } bit_kind_t;

    localparam logic [DATA_W-1:0] MASK_RW_BITS = 16'hFF0F;
    localparam int SIDE_BIT = 9;

    // Return the class of status bit idx.
    function automatic bit_kind_t kind_of(input int idx);
        if (idx >= 10)            return K_SW;
        else if (idx == SIDE_BIT) return K_SIDE;
        else if (idx == 8)        return K_W1C;
        else if (idx <= 3)        return K_W1C;
        else                      return K_NONE;
    endfunction
endpackage

// File: rtl/phl_irq_mask_reg.sv
// Module: interrupt mask register.
// Holds the writable mask bits. Reserved bits are tied to 0 through the
// package mask. Assumes wr_en is already decoded for this register.
module phl_irq_mask_reg
    import phl_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mask_q
);
    // Load the writable bits on a decoded write.
    always_ff @(posedge clk) begin
        if (!rst_n)     mask_q <= '0;
        else if (wr_en) mask_q <= wdata & MASK_RW_BITS;
    end
endmodule

// File: rtl/phl_irq_status_reg.sv
// Module: interrupt status register.
// One cell per bit, picked by the package class. Set events win over
// clears. Assumes events are one-cycle pulses already placed on their bit.
module phl_irq_status_reg
    import phl_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] evt,
    input  logic              side_clr,
    output logic [DATA_W-1:0] stat_q
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (kind_of(i) == K_SW) begin : g_sw
            logic b;
            // Software bit: takes the written value.
            always_ff @(posedge clk) begin
                if (!rst_n)     b <= 1'b0;
                else if (wr_en) b <= wdata[i];
            end
            assign stat_q[i] = b;
        end else if (kind_of(i) == K_W1C) begin : g_w1c
            logic b;
            // Event sets; write-1 clears; set has priority.
            always_ff @(posedge clk) begin
                if (!rst_n)                  b <= 1'b0;
                else if (evt[i])             b <= 1'b1;
                else if (wr_en && wdata[i])  b <= 1'b0;
            end
            assign stat_q[i] = b;
        end else if (kind_of(i) == K_SIDE) begin : g_side
            logic b;
            // Event sets; side access clears; set has priority.
            always_ff @(posedge clk) begin
                if (!rst_n)        b <= 1'b0;
                else if (evt[i])   b <= 1'b1;
                else if (side_clr) b <= 1'b0;
            end
            assign stat_q[i] = b;
        end else begin : g_rsv
            assign stat_q[i] = 1'b0;
        end
    end

    // Inputs that no cell uses, by construction of the layout.
    logic unused_inputs;
    assign unused_inputs = ^{evt[15:10], evt[7:4], wdata[9], wdata[7:4]};
endmodule

// File: rtl/phl_irq_pin.sv
// Module: registered active-low interrupt pin.
// Drives low when any unmasked status bit is set. The pin lags the
// registers by one cycle.
module phl_irq_pin
    import phl_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] stat_q,
    input  logic [DATA_W-1:0] mask_q,
    output logic              irq_n
);
    // Register the reduced pending term.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_n <= 1'b1;
        else        irq_n <= ~|(stat_q & ~mask_q);
    end
endmodule

// File: rtl/phl_irq_ctrl.sv
// Module: masked interrupt status controller (top).
// Decodes the register port, gathers hardware events onto their status
// bits and muxes read data. Assumes single-cycle strobes from the host.
module phl_irq_ctrl
    import phl_irq_pkg::*;
#(
    parameter int              ADDR_W    = 5,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 5'd18,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 5'd19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [15:0]       reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [15:0]       reg_rdata,
    input  logic              rxcmd_hi_acc,
    input  logic              ev_rxcmd_vld,
    input  logic              ev_txcmd_rdy,
    input  logic              ev_pkt_rx,
    input  logic              ev_pkt_tx,
    input  logic              ev_rcmd_rx,
    input  logic              ev_rcmd_tx,
    output logic              irq_n
);
    logic              mask_wr, stat_wr;
    logic [DATA_W-1:0] mask_q, stat_q, evt_vec;

    assign mask_wr = reg_wr && (reg_addr == MASK_ADDR);
    assign stat_wr = reg_wr && (reg_addr == STAT_ADDR);

    // Place each event on its status bit position.
    assign evt_vec = {6'b0, ev_rxcmd_vld, ev_txcmd_rdy, 4'b0,
                      ev_pkt_rx, ev_pkt_tx, ev_rcmd_rx, ev_rcmd_tx};

    phl_irq_mask_reg u_mask (
        .clk(clk), .rst_n(rst_n), .wr_en(mask_wr),
        .wdata(reg_wdata), .mask_q(mask_q)
    );

    phl_irq_status_reg u_stat (
        .clk(clk), .rst_n(rst_n), .wr_en(stat_wr), .wdata(reg_wdata),
        .evt(evt_vec), .side_clr(rxcmd_hi_acc), .stat_q(stat_q)
    );

    phl_irq_pin u_pin (
        .clk(clk), .rst_n(rst_n), .stat_q(stat_q),
        .mask_q(mask_q), .irq_n(irq_n)
    );

    // Read mux: zero unless a read hits a mapped register.
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            if (reg_addr == MASK_ADDR)      reg_rdata = mask_q;
            else if (reg_addr == STAT_ADDR) reg_rdata = stat_q;
        end
    end
endmodule

// File: rtl/phl_irq_ctrl_chk.sv
// Module: assertion checker for phl_irq_ctrl, attached by bind.
module phl_irq_ctrl_chk #(
    parameter int                ADDR_W    = 5,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 5'd19
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [15:0]       reg_wdata,
    input logic              reg_wr,
    input logic              rxcmd_hi_acc,
    input logic              ev_rxcmd_vld,
    input logic              ev_pkt_rx,
    input logic [15:0]       mask_q,
    input logic [15:0]       stat_q,
    input logic              irq_n
);
    logic swr;
    assign swr = reg_wr && (reg_addr == STAT_ADDR);

    p_reserved_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q[7:4] == 4'b0);
    p_sw_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        swr |=> stat_q[15:10] == $past(reg_wdata[15:10]));
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[3] && !(swr && reg_wdata[3])) |=> stat_q[3]);
    p_w1c_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (swr && !reg_wdata[0] && stat_q[0]) |=> stat_q[0]);
    p_side_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rxcmd_hi_acc && !ev_rxcmd_vld) |=> !stat_q[9]);
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pkt_rx |=> stat_q[3]);
    p_irq_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_n == ~|($past(stat_q & ~mask_q)));
endmodule

bind phl_irq_ctrl phl_irq_ctrl_chk #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .rxcmd_hi_acc(rxcmd_hi_acc), .ev_rxcmd_vld(ev_rxcmd_vld),
    .ev_pkt_rx(ev_pkt_rx), .mask_q(mask_q), .stat_q(stat_q), .irq_n(irq_n)
);

// File: tb/phl_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module phl_irq_ctrl_tb_top;
    localparam logic [4:0] A_MASK = 5'd18;
    localparam logic [4:0] A_STAT = 5'd19;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, rxcmd_hi_acc = 1'b0;
    logic [5:0]  ev = '0;   // {rxcmd_vld, txcmd_rdy, pkt_rx, pkt_tx, rcmd_rx, rcmd_tx}
    logic [15:0] reg_rdata;
    logic        irq_n;

    int errors = 0, checks = 0;
    bit done = 0;

    // Bench model state
    logic [15:0] m_mask = '0, m_stat = '0;
    logic        m_irq_n = 1'b1;

    always #2 clk = ~clk;

    phl_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .rxcmd_hi_acc(rxcmd_hi_acc), .ev_rxcmd_vld(ev[5]), .ev_txcmd_rdy(ev[4]),
        .ev_pkt_rx(ev[3]), .ev_pkt_tx(ev[2]), .ev_rcmd_rx(ev[1]),
        .ev_rcmd_tx(ev[0]), .irq_n(irq_n)
    );

    function automatic logic [15:0] exp_read(logic rd, logic [4:0] a,
                                             logic [15:0] mk, logic [15:0] st);
        if (!rd) return 16'h0;
        if (a == A_MASK) return mk;
        if (a == A_STAT) return st;
        return 16'h0;
    endfunction

    function automatic logic [15:0] next_stat(logic [15:0] st, logic wr, logic [4:0] a,
                                              logic [15:0] wd, logic [5:0] e, logic hi);
        logic [15:0] n = st;
        if (wr && a == A_STAT) begin
            n[15:10] = wd[15:10];
            n = n & ~(wd & 16'h010F);
        end
        if (hi) n[9] = 1'b0;
        n = n | {6'b0, e[5], e[4], 4'b0, e[3:0]};
        return n;
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive, check outputs against model, advance model at the edge.
    task automatic cyc(string tag, logic wr, logic rd, logic [4:0] a,
                       logic [15:0] wd, logic [5:0] e, logic hi);
        @(negedge clk);
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
        ev = e; rxcmd_hi_acc = hi;
        #1;
        chk({tag, " R9 irq_n"}, {15'b0, irq_n}, {15'b0, m_irq_n});
        chk({tag, " rdata"}, reg_rdata, exp_read(rd, a, m_mask, m_stat));
        @(posedge clk);
        m_irq_n = ~|(m_stat & ~m_mask);
        m_stat  = next_stat(m_stat, wr, a, wd, e, hi);
        if (wr && a == A_MASK) m_mask = wd & 16'hFF0F;
    endtask

    task automatic rd_stat(string tag); cyc(tag, 0, 1, A_STAT, 0, 0, 0); endtask
    task automatic rd_mask(string tag); cyc(tag, 0, 1, A_MASK, 0, 0, 0); endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state
        rd_mask("R1 mask after reset");
        rd_stat("R1 status after reset");
        // R2 reserved mask bits
        cyc("R2 write mask", 1, 0, A_MASK, 16'hFFFF, 0, 0);
        rd_mask("R2 mask readback 7..4 zero");
        cyc("R2 clear mask", 1, 0, A_MASK, 16'h0000, 0, 0);
        // R3 software bits set then cleared
        cyc("R3 sw set", 1, 0, A_STAT, 16'hA400, 0, 0);
        rd_stat("R3 sw readback");
        cyc("R9 irq low after sw", 0, 0, 0, 0, 0, 0);
        cyc("R3 sw clear", 1, 0, A_STAT, 16'h0000, 0, 0);
        rd_stat("R3 sw cleared");
        // R4 events set and hold; R9 one-cycle pin latency
        cyc("R4 events", 0, 0, 0, 0, 6'b011111, 0);
        cyc("R9 first cycle", 0, 0, 0, 0, 0, 0);
        rd_stat("R4 hold");
        // R5 write 0 no effect, write 1 clears
        cyc("R5 w0", 1, 0, A_STAT, 16'h0000, 0, 0);
        rd_stat("R5 after w0");
        cyc("R5 w1 bits 8,2", 1, 0, A_STAT, 16'h0104, 0, 0);
        rd_stat("R5 after w1");
        // R6 bit 9: write ignored, side access clears
        cyc("R6 set", 0, 0, 0, 0, 6'b100000, 0);
        cyc("R6 write ignored", 1, 0, A_STAT, 16'h0200, 0, 0);
        rd_stat("R6 still set");
        cyc("R6 hi access", 0, 0, 0, 0, 0, 1);
        rd_stat("R6 cleared");
        // R7 set wins
        cyc("R7 w1c vs event", 1, 0, A_STAT, 16'h0008, 6'b001000, 0);
        cyc("R7 side vs event", 0, 0, 0, 0, 6'b100000, 1);
        rd_stat("R7 both set");
        // R8 full mask: status still visible, pin releases
        cyc("R8 full mask", 1, 0, A_MASK, 16'hFFFF, 0, 0);
        cyc("R8 settle", 0, 0, 0, 0, 0, 0);
        rd_stat("R8 status under mask");
        cyc("R8 open bit 3", 1, 0, A_MASK, 16'hFFF7, 0, 0);
        cyc("R9 open bit", 0, 0, 0, 0, 0, 0);
        rd_mask("R9 pin via bit 3");
        // R10 read gating and unmapped address
        cyc("R10 rd low", 0, 0, A_STAT, 0, 0, 0);
        cyc("R10 unmapped", 0, 1, 5'd3, 0, 0, 0);
        // Random phase
        for (int i = 0; i < 3000; i++) begin
            logic [4:0] a;
            int sel = $urandom_range(0, 9);
            a = (sel < 4) ? A_MASK : (sel < 8) ? A_STAT : 5'($urandom_range(0, 31));
            cyc("R8/R10 random", ($urandom_range(0, 3) == 0), $urandom_range(0, 1) == 1,
                a, 16'($urandom), 6'($urandom & $urandom), ($urandom_range(0, 7) == 0));
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule